// File: doc/BRIEF.md
# Erase Status Poll Word Generator

This block sits between a flash erase sequencer and the host read path. While a sector erase is being collected, running, suspended or has overrun its time limit, host reads do not return array contents. They return a status word that software polls to follow the erase. The word carries a fixed-zero busy marker. It carries a bit that flips on every completed read and a second flipping bit that moves only when the read address falls in a sector marked for erase. It also carries a flag that says whether new sectors can still be added, and a flag for a time-limit overrun. An active-low busy output follows the same phases. In read mode the block passes array data through unchanged.

The sequencer supplies its phase as a 3-bit code and the set of sectors selected for erase as a bit mask, one bit per sector. A sector is a 2^SECT_SHIFT-word region of the address space.

A small state machine registers the phase. It has five states:
- ST_READ: array pass-through.
- ST_WINDOW: sectors may still be added.
- ST_ERASE: embedded erase running.
- ST_SUSP: erase suspended.
- ST_FAULT: time limit exceeded.

On every clock the state machine moves to the state named by the phase input; codes 5 to 7 map to ST_READ. The named transitions that matter are:
- Entering ST_READ from any other state, which clears both flip bits.
- Moving between any two busy or suspended states, which keeps the flip bits.

Top module: `erase_poll_status`

## Requirements
- R1: Phase codes are 0 read, 1 window, 2 erase, 3 suspended, 4 timed out; 5 to 7 act as read. The registered state follows the phase input one clock later. In read mode data_o equals array_data_i.
- R2: In every non-read state, bit 7 of data_o is 0.
- R3: Bit 6 inverts once per read strobe in the window, erase and timed-out states, and holds its value in the suspended state.
- R4: Bit 3 is 0 in the window state and 1 in the erase, suspended and timed-out states.
- R5: Bit 5 is 1 in the timed-out state and 0 in every other non-read state.
- R6: Bit 2 inverts once per read strobe in any non-read state when bit (addr_i >> SECT_SHIFT) of pend_mask_i is set at the strobe. Otherwise it holds its value.
- R7: busy_n_o is 0 in the window, erase and timed-out states, and 1 in the read and suspended states.
- R8: A read strobe is a 0-to-1 transition of oe_n_i, sampled on the clock, while ce_n_i is 0. A read with ce_n_i held at 1 advances nothing, and a read that is held for several clocks advances each flip bit once.
- R9: In non-read states, bits 4, 1 and 0 and all bits above 7 read 0.
- R10: Both flip bits are 0 after reset and are cleared on the clock that enters the read state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 3 | Sequencer phase code |
| pend_mask_i | input | NSECT | Sectors selected for erase, one bit each |
| addr_i | input | AW | Host read address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| array_data_i | input | DW | Array data for read mode |
| data_o | output | DW | Returned read word |
| busy_n_o | output | 1 | Ready/busy, low while busy |

## Verification
The hardest situation to reach is a bit 2 flip history that mixes reads inside and outside the selected sectors. That history has to carry across a suspend and a resume, and then be wiped by a return to read mode. The stimulus reaches it with long random runs in which the phase, the sector mask and the read address all change between reads. The bench also issues directed reads that are stretched over several clocks or made with chip enable high, so that only genuine strobes move the flip bits.

// File: rtl/erase_poll_pkg.sv
package erase_poll_pkg;

    typedef enum logic [2:0] {
        ST_READ   = 3'd0,
        ST_WINDOW = 3'd1,
        ST_ERASE  = 3'd2,
        ST_SUSP   = 3'd3,
        ST_FAULT  = 3'd4
    } poll_state_t;

    localparam int BIT_DONE   = 7;
    localparam int BIT_TOG    = 6;
    localparam int BIT_FAULT  = 5;
    localparam int BIT_CLOSED = 3;
    localparam int BIT_SECT   = 2;

endpackage

// File: rtl/erase_poll_strobe.sv
module erase_poll_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic oe_n_i,
    output logic strobe_o
);

    logic oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b1;
        else        oe_q <= oe_n_i;
    end

    assign strobe_o = !ce_n_i && !oe_q && oe_n_i;

endmodule

// File: rtl/erase_poll_fsm.sv
module erase_poll_fsm
    import erase_poll_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  phase_i,
    output poll_state_t state_o,
    output logic        busy_n_o,
    output logic        tog_all_en_o,
    output logic        tog_sect_en_o,
    output logic        clear_o
);

    poll_state_t state_q, state_d;

    always_comb begin
        unique case (phase_i)
            3'd1:    state_d = ST_WINDOW;
            3'd2:    state_d = ST_ERASE;
            3'd3:    state_d = ST_SUSP;
            3'd4:    state_d = ST_FAULT;
            default: state_d = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    always_comb begin
        busy_n_o      = 1'b1;
        tog_all_en_o  = 1'b0;
        tog_sect_en_o = 1'b0;
        clear_o       = (state_q != ST_READ) && (state_d == ST_READ);
        unique case (state_q)
            ST_READ: begin
                busy_n_o = 1'b1;
            end
            ST_WINDOW, ST_ERASE, ST_FAULT: begin
                busy_n_o      = 1'b0;
                tog_all_en_o  = 1'b1;
                tog_sect_en_o = 1'b1;
            end
            ST_SUSP: begin
                busy_n_o      = 1'b1;
                tog_sect_en_o = 1'b1;
            end
            default: begin
                busy_n_o = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;

    AST_STATE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 3'd2) |=> (state_q == ST_ERASE)); // R1
    AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP) |-> busy_n_o); // R7

endmodule

// File: rtl/erase_poll_toggles.sv
module erase_poll_toggles (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic all_en_i,
    input  logic sect_en_i,
    input  logic hit_i,
    input  logic clear_i,
    output logic tog_all_o,
    output logic tog_sect_o
);

    logic tog_all_q, tog_sect_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_all_q  <= 1'b0;
            tog_sect_q <= 1'b0;
        end else if (clear_i) begin
            tog_all_q  <= 1'b0;
            tog_sect_q <= 1'b0;
        end else if (strobe_i) begin
            if (all_en_i)           tog_all_q  <= !tog_all_q;
            if (sect_en_i && hit_i) tog_sect_q <= !tog_sect_q;
        end
    end

    assign tog_all_o  = tog_all_q;
    assign tog_sect_o = tog_sect_q;

    AST_ALL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && all_en_i && !clear_i) |=> (tog_all_q != $past(tog_all_q))); // R3
    AST_ALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && !clear_i) |=> $stable(tog_all_q)); // R8
    AST_SECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i && !clear_i) |=> $stable(tog_sect_q)); // R6
    AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!tog_all_q && !tog_sect_q)); // R10

endmodule

// File: rtl/erase_poll_status.sv
module erase_poll_status
    import erase_poll_pkg::*;
#(
    parameter int AW         = 10,
    parameter int SECT_SHIFT = 6,
    parameter int DW         = 8,
    localparam int NSECT     = 1 << (AW - SECT_SHIFT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       phase_i,
    input  logic [NSECT-1:0] pend_mask_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             ce_n_i,
    input  logic             oe_n_i,
    input  logic [DW-1:0]    array_data_i,
    output logic [DW-1:0]    data_o,
    output logic             busy_n_o
);

    poll_state_t      state;
    logic             strobe, all_en, sect_en, clear;
    logic             tog_all, tog_sect, hit;
    logic [NSECT-1:0] sect_dec;
    logic [DW-1:0]    status_word;

    erase_poll_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n_i   (ce_n_i),
        .oe_n_i   (oe_n_i),
        .strobe_o (strobe)
    );

    erase_poll_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_i       (phase_i),
        .state_o       (state),
        .busy_n_o      (busy_n_o),
        .tog_all_en_o  (all_en),
        .tog_sect_en_o (sect_en),
        .clear_o       (clear)
    );

    generate
        for (genvar s = 0; s < NSECT; s++) begin : g_dec
            assign sect_dec[s] = ((addr_i >> SECT_SHIFT) == AW'(s));
        end
    endgenerate

    assign hit = |(sect_dec & pend_mask_i);

    erase_poll_toggles u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (strobe),
        .all_en_i   (all_en),
        .sect_en_i  (sect_en),
        .hit_i      (hit),
        .clear_i    (clear),
        .tog_all_o  (tog_all),
        .tog_sect_o (tog_sect)
    );

    always_comb begin
        status_word             = '0;
        status_word[BIT_DONE]   = 1'b0;
        status_word[BIT_TOG]    = tog_all;
        status_word[BIT_FAULT]  = (state == ST_FAULT);
        status_word[BIT_CLOSED] = (state != ST_WINDOW);
        status_word[BIT_SECT]   = tog_sect;
    end

    always_comb begin
        unique case (state)
            ST_READ: data_o = array_data_i;
            default: data_o = status_word;
        endcase
    end

    AST_BUSY_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n_o |-> !data_o[BIT_DONE]); // R2
    AST_FAULT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        data_o[BIT_FAULT] && (state != ST_READ) |-> !busy_n_o); // R5
    AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |-> (data_o == array_data_i) && busy_n_o); // R1
    AST_WINDOW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW) |-> !data_o[BIT_CLOSED] && !busy_n_o); // R4

endmodule

// File: tb/erase_poll_status_tb.sv
module erase_poll_status_tb_top;

    localparam int AW = 10, SH = 6, DW = 8, NS = 1 << (AW - SH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    phase = 3'd0;
    logic [NS-1:0] mask = '0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1;
    logic [DW-1:0] arr = '0;
    logic [DW-1:0] dout;
    logic          busy_n;

    int n_chk = 0, n_bad = 0;
    int m_st = 0;
    logic m_t6 = 1'b0, m_t2 = 1'b0;

    always #5 clk = ~clk;

    erase_poll_status #(.AW(AW), .SECT_SHIFT(SH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .pend_mask_i(mask),
        .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n), .array_data_i(arr),
        .data_o(dout), .busy_n_o(busy_n)
    );

    function automatic int norm(input logic [2:0] p);
        return (p > 3'd4) ? 0 : int'(p);
    endfunction

    function automatic logic [DW-1:0] exp_word(input int st, input logic t6,
                                               input logic t2, input logic [DW-1:0] a);
        logic [DW-1:0] w;
        if (st == 0) return a;
        w = '0;
        w[6] = t6;
        w[5] = (st == 4);
        w[3] = (st != 1);
        w[2] = t2;
        return w;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, dout, exp_word(m_st, m_t6, m_t2, arr));
        check("R7", DW'(busy_n), DW'(!(m_st == 1 || m_st == 2 || m_st == 4)));
    endtask

    task automatic set_phase(input logic [2:0] p);
        int nx;
        phase = p;
        nx = norm(p);
        @(posedge clk);
        if (m_st != 0 && nx == 0) begin m_t6 = 1'b0; m_t2 = 1'b0; end
        m_st = nx;
        @(negedge clk);
        check_outputs("R1");
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit ce_hi, input int hold);
        logic hitb;
        addr = a;
        ce_n = ce_hi;
        oe_n = 1'b0;
        repeat (hold) @(negedge clk);
        check_outputs("R3");
        hitb = mask[a >> SH];
        oe_n = 1'b1;
        @(posedge clk);
        if (!ce_hi) begin
            if (m_st == 1 || m_st == 2 || m_st == 4) m_t6 = !m_t6;
            if (m_st != 0 && hitb) m_t2 = !m_t2;
        end
        @(negedge clk);
        ce_n = 1'b1;
        check_outputs(ce_hi ? "R8" : "R6");
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234));
        arr = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R10");

        // directed: window state, in-sector and out-of-sector reads
        mask = 16'h0004;
        set_phase(3'd1);
        check("R4", DW'(dout[3]), 8'h0);
        check("R2", DW'(dout[7]), 8'h0);
        do_read(10'h085, 1'b0, 1);
        do_read(10'h3C0, 1'b0, 1);
        do_read(10'h085, 1'b1, 1);
        do_read(10'h090, 1'b0, 4);
        set_phase(3'd2);
        do_read(10'h081, 1'b0, 1);
        set_phase(3'd3);
        do_read(10'h081, 1'b0, 2);
        do_read(10'h000, 1'b0, 1);
        set_phase(3'd4);
        check("R5", DW'(dout[5]), 8'h1);
        check("R9", dout & 8'h13, 8'h0);
        do_read(10'h0BF, 1'b0, 1);
        set_phase(3'd6);
        check("R10", DW'({dout[6], dout[2]}), DW'({arr[6], arr[2]}));

        for (int i = 0; i < 600; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            arr = DW'($urandom);
            if (k == 0)      set_phase(3'($urandom_range(0, 7)));
            else if (k == 1) mask = NS'($urandom);
            else             do_read(AW'($urandom), ($urandom_range(0, 7) == 0),
                                     int'($urandom_range(1, 3)));
        end

        set_phase(3'd0);
        check("R10", dout, arr);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule